// File: doc/BRIEF.md
# Hamming Single-Error-Correcting Codec

This block protects an 8-bit data word with 4 check bits, forming a 12-bit stored codeword. The write side is an encoder that turns a data word into a codeword. The read side is a decoder that takes a fetched codeword and rebuilds the check bits from its data field. It compares the rebuilt check bits with the stored ones to form a syndrome. The decoder then classifies the fault and repairs a single faulty data bit.

Both paths are combinational. A parameter can add one output register stage that covers both paths, and this stage is enabled by default. The data width is also a parameter. The check-bit count and the codeword width are derived from it. The storage array lies outside the block, and so does any scrubbing of that array.

Top module: `hsec_codec`

## Requirements
- R1: Codeword bit index p-1 holds position p, for positions 1 to 12. The check bits sit at positions 1, 2, 4 and 8, which are indices 0, 1, 3 and 7. Data bits 0 to 7 occupy positions 3, 5, 6, 7, 9, 10, 11 and 12, in that ascending order.
- R2: Check bit k is the even parity of every data bit whose position number has bit k set.
- R3: `rd_syndrome` bit k is the stored check bit k XOR check bit k recomputed from the fetched data. When the syndrome is zero, the fetched data is output unchanged and every status flag is low.
- R4: A syndrome with exactly one bit set marks a check-bit fault. The fetched data is output unchanged, `rd_err`, `rd_fixed` and `rd_chk_fault` are high, and `rd_uncorr` is low.
- R5: A syndrome with two or more bits set and a value from 3 to 12 is taken as a data-bit position. The data bit at that position is inverted on output, `rd_err` and `rd_fixed` are high, and `rd_chk_fault` and `rd_uncorr` are low.
- R6: A syndrome value of 13, 14 or 15 points at no position. `rd_uncorr` and `rd_err` are high, `rd_fixed` and `rd_chk_fault` are low, and the fetched data is output unchanged.
- R7: Decoding an unaltered codeword produced by the encoder returns the original data with a zero syndrome and all flags low.
- R8: With the output stage enabled, every output takes the value of its inputs at the first rising clock edge after they are applied, and holds that value until the next edge. While `rst_n` is low, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output stage |
| rst_n | input | 1 | Active-low synchronous reset of the output stage |
| wr_data | input | 8 | Data word to encode |
| wr_code | output | 12 | Encoded codeword |
| rd_code | input | 12 | Fetched codeword to decode |
| rd_data | output | 8 | Corrected data |
| rd_syndrome | output | 4 | Syndrome of the fetched codeword |
| rd_err | output | 1 | Syndrome is nonzero |
| rd_fixed | output | 1 | A single fault was located, and the output data is correct |
| rd_chk_fault | output | 1 | The fault lies in a check bit |
| rd_uncorr | output | 1 | The syndrome points outside the codeword |

## Verification
A wrong coverage mask in the parity tree would show up in the very next registered cycle, either as a nonzero syndrome on a clean codeword or as a wrong check bit in `wr_code`. A mis-mapped data position would show up when a single injected flip repairs the wrong data bit, or when a check-bit fault is reported as a data fault. Because the decoder holds no state between words, a fault always appears one edge after the offending codeword is applied. The bench therefore sweeps every single-bit flip and every out-of-range syndrome, together with random one-flip and two-flip patterns.

// File: rtl/hsec_pkg.sv
package hsec_pkg;

    typedef struct packed {
        logic err;
        logic fixed;
        logic chk_fault;
        logic uncorr;
    } hsec_flags_t;

    // smallest k with 2^k >= data + k + 1
    function automatic int chk_width(input int dw);
        int k;
        k = 0;
        while ((1 << k) < dw + k + 1) k++;
        return k;
    endfunction

    function automatic bit is_pow2(input int p);
        return (p > 0) && ((p & (p - 1)) == 0);
    endfunction

    // codeword position (1-based) of data bit idx
    function automatic int data_pos(input int idx);
        int cnt;
        int res;
        cnt = 0;
        res = 0;
        for (int p = 1; p <= 2 * idx + 4; p++) begin
            if (!is_pow2(p)) begin
                if (cnt == idx) res = p;
                cnt++;
            end
        end
        return res;
    endfunction

    // data bits covered by check bit k
    function automatic logic [63:0] cover_mask(input int k, input int dw);
        logic [63:0] m;
        m = '0;
        for (int i = 0; i < dw; i++) begin
            if (((data_pos(i) >> k) & 1) == 1) m[i] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/hsec_encoder.sv
module hsec_encoder #(
    parameter int DATA_W = 8,
    localparam int CHK_W = hsec_pkg::chk_width(DATA_W),
    localparam int CODE_W = DATA_W + CHK_W
) (
    input  logic [DATA_W-1:0] data,
    output logic [CODE_W-1:0] code,
    output logic [CHK_W-1:0]  chk
);
    // data bits scattered to non-power-of-two positions
    for (genvar i = 0; i < DATA_W; i++) begin : g_data
        localparam int POS = hsec_pkg::data_pos(i);
        assign code[POS-1] = data[i];
    end

    // even parity per check column
    for (genvar k = 0; k < CHK_W; k++) begin : g_chk
        localparam logic [63:0] MASK = hsec_pkg::cover_mask(k, DATA_W);
        assign chk[k] = ^(data & MASK[DATA_W-1:0]);
        assign code[(1 << k) - 1] = chk[k];
    end
endmodule

// File: rtl/hsec_syndrome.sv
module hsec_syndrome #(
    parameter int DATA_W = 8,
    localparam int CHK_W = hsec_pkg::chk_width(DATA_W),
    localparam int CODE_W = DATA_W + CHK_W
) (
    input  logic [CODE_W-1:0] code,
    output logic [DATA_W-1:0] data,
    output logic [CHK_W-1:0]  syn
);
    logic [CHK_W-1:0]  stored_chk;
    logic [CHK_W-1:0]  fresh_chk;
    logic [CODE_W-1:0] fresh_code;

    for (genvar i = 0; i < DATA_W; i++) begin : g_pick
        localparam int POS = hsec_pkg::data_pos(i);
        assign data[i] = code[POS-1];
    end

    for (genvar k = 0; k < CHK_W; k++) begin : g_stored
        assign stored_chk[k] = code[(1 << k) - 1];
    end

    hsec_encoder #(.DATA_W(DATA_W)) u_regen (
        .data (data),
        .code (fresh_code),
        .chk  (fresh_chk)
    );

    assign syn = stored_chk ^ fresh_chk;
endmodule

// File: rtl/hsec_corrector.sv
module hsec_corrector #(
    parameter int DATA_W = 8,
    localparam int CHK_W = hsec_pkg::chk_width(DATA_W),
    localparam int CODE_W = DATA_W + CHK_W
) (
    input  logic [CHK_W-1:0]        syn,
    input  logic [DATA_W-1:0]       data_in,
    output logic [DATA_W-1:0]       data_out,
    output hsec_pkg::hsec_flags_t   flags
);
    localparam logic [CHK_W-1:0] TOP_POS = CHK_W'(CODE_W);

    logic [DATA_W-1:0] flip;
    logic              nonzero;
    logic              single;
    logic              in_range;

    for (genvar i = 0; i < DATA_W; i++) begin : g_flip
        localparam logic [CHK_W-1:0] POS_V = CHK_W'(hsec_pkg::data_pos(i));
        assign flip[i] = (syn == POS_V);
    end

    always_comb begin
        nonzero  = |syn;
        single   = nonzero && ((syn & (syn - 1'b1)) == '0);
        in_range = (syn <= TOP_POS);
        data_out = data_in ^ flip;
        flags.err       = nonzero;
        flags.chk_fault = single;
        flags.fixed     = nonzero && in_range;
        flags.uncorr    = nonzero && !in_range;
    end
endmodule

// File: rtl/hsec_codec.sv
module hsec_codec #(
    parameter int DATA_W = 8,
    parameter bit REG_OUT = 1'b1,
    localparam int CHK_W = hsec_pkg::chk_width(DATA_W),
    localparam int CODE_W = DATA_W + CHK_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] wr_data,
    output logic [CODE_W-1:0] wr_code,
    input  logic [CODE_W-1:0] rd_code,
    output logic [DATA_W-1:0] rd_data,
    output logic [CHK_W-1:0]  rd_syndrome,
    output logic              rd_err,
    output logic              rd_fixed,
    output logic              rd_chk_fault,
    output logic              rd_uncorr
);
    typedef struct packed {
        logic [CODE_W-1:0]     code;
        logic [DATA_W-1:0]     data;
        logic [CHK_W-1:0]      syn;
        hsec_pkg::hsec_flags_t flags;
    } out_t;

    logic [CODE_W-1:0]     enc_code;
    logic [CHK_W-1:0]      enc_chk;
    logic [DATA_W-1:0]     fetched;
    logic [CHK_W-1:0]      syn;
    logic [DATA_W-1:0]     fixed_data;
    hsec_pkg::hsec_flags_t flags;

    out_t out_d;
    out_t out_q;

    hsec_encoder #(.DATA_W(DATA_W)) u_enc (
        .data (wr_data),
        .code (enc_code),
        .chk  (enc_chk)
    );

    hsec_syndrome #(.DATA_W(DATA_W)) u_syn (
        .code (rd_code),
        .data (fetched),
        .syn  (syn)
    );

    hsec_corrector #(.DATA_W(DATA_W)) u_fix (
        .syn      (syn),
        .data_in  (fetched),
        .data_out (fixed_data),
        .flags    (flags)
    );

    always_comb begin
        out_d       = '0;
        out_d.code  = enc_code;
        out_d.data  = fixed_data;
        out_d.syn   = syn;
        out_d.flags = flags;
    end

    if (REG_OUT) begin : g_reg
        always_ff @(posedge clk) begin
            if (!rst_n) out_q <= '0;
            else        out_q <= out_d;
        end
    end else begin : g_comb
        always_comb out_q = out_d;
    end

    assign wr_code      = out_q.code;
    assign rd_data      = out_q.data;
    assign rd_syndrome  = out_q.syn;
    assign rd_err       = out_q.flags.err;
    assign rd_fixed     = out_q.flags.fixed;
    assign rd_chk_fault = out_q.flags.chk_fault;
    assign rd_uncorr    = out_q.flags.uncorr;

    // R3: clean syndrome leaves data untouched and raises nothing
    a_r3_clean_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (syn == '0) |-> (!flags.err && fixed_data == fetched));

    // R4: check-bit fault keeps the data
    a_r4_chk_keeps_data: assert property (@(posedge clk) disable iff (!rst_n)
        flags.chk_fault |-> (fixed_data == fetched && flags.fixed && !flags.uncorr));

    // R5: a data repair changes exactly one bit
    a_r5_one_bit_flip: assert property (@(posedge clk) disable iff (!rst_n)
        (flags.fixed && !flags.chk_fault) |-> ($countones(fixed_data ^ fetched) == 1));

    // R6: out-of-range syndrome leaves data unchanged
    a_r6_uncorr_keeps_data: assert property (@(posedge clk) disable iff (!rst_n)
        flags.uncorr |-> (fixed_data == fetched && flags.err));

    // R4, R5, R6: repaired and uncorrectable are exclusive and cover every error
    a_r6_flag_partition: assert property (@(posedge clk) disable iff (!rst_n)
        ($onehot0({flags.fixed, flags.uncorr}) && (flags.err == (flags.fixed | flags.uncorr))));
endmodule

// File: tb/hsec_codec_bench.sv
module hsec_codec_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  wr_data = '0;
    logic [11:0] wr_code;
    logic [11:0] rd_code = '0;
    logic [7:0]  rd_data;
    logic [3:0]  rd_syndrome;
    logic        rd_err, rd_fixed, rd_chk_fault, rd_uncorr;

    int checks = 0;
    int failures = 0;

    always #10 clk = ~clk;

    hsec_codec u_hsec_codec (
        .clk(clk), .rst_n(rst_n), .wr_data(wr_data), .wr_code(wr_code),
        .rd_code(rd_code), .rd_data(rd_data), .rd_syndrome(rd_syndrome),
        .rd_err(rd_err), .rd_fixed(rd_fixed), .rd_chk_fault(rd_chk_fault),
        .rd_uncorr(rd_uncorr)
    );

    int dpos [8] = '{3, 5, 6, 7, 9, 10, 11, 12};

    function automatic logic [11:0] m_enc(input logic [7:0] d);
        logic [11:0] c;
        c = '0;
        for (int i = 0; i < 8; i++) c[dpos[i]-1] = d[i];
        for (int k = 0; k < 4; k++) begin
            logic p;
            p = 1'b0;
            for (int i = 0; i < 8; i++) if (dpos[i][k]) p ^= d[i];
            c[(1 << k) - 1] = p;
        end
        return c;
    endfunction

    // returns {data, syn, err, fixed, chk_fault, uncorr}
    function automatic logic [15:0] m_dec(input logic [11:0] c);
        logic [7:0]  d;
        logic [11:0] r;
        logic [3:0]  s;
        logic        e, f, cf, u;
        for (int i = 0; i < 8; i++) d[i] = c[dpos[i]-1];
        r = m_enc(d);
        for (int k = 0; k < 4; k++) s[k] = c[(1 << k) - 1] ^ r[(1 << k) - 1];
        e = (s != 0);
        cf = (s == 1 || s == 2 || s == 4 || s == 8);
        u = (s > 12);
        f = e && !u;
        if (f && !cf) begin
            for (int i = 0; i < 8; i++) if (dpos[i] == s) d[i] = ~d[i];
        end
        return {d, s, e, f, cf, u};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] outs();
        return {rd_data, rd_syndrome, rd_err, rd_fixed, rd_chk_fault, rd_uncorr};
    endfunction

    // drive at negedge, sample at the following negedge (one register)
    task automatic run_vec(input logic [7:0] d, input logic [11:0] c, input string req);
        logic [15:0] prev;
        @(negedge clk);
        prev = outs();
        wr_data = d;
        rd_code = c;
        #2;
        chk({"R8 hold before edge ", req}, 32'(outs()), 32'(prev));
        @(negedge clk);
        chk({"R1 R2 encode ", req}, 32'(wr_code), 32'(m_enc(d)));
        chk({"decode ", req}, 32'(outs()), 32'(m_dec(c)));
    endtask

    initial begin
        logic [11:0] base;
        // R8: reset holds outputs at zero
        wr_data = 8'hA5;
        rd_code = 12'hFFF;
        repeat (3) @(negedge clk);
        chk("R8 reset wr_code", 32'(wr_code), 32'h0);
        chk("R8 reset rd outputs", 32'(outs()), 32'h0);
        rst_n = 1'b1;

        // R1: layout for single data bits
        for (int i = 0; i < 8; i++) run_vec(8'(1 << i), 12'h0, "R1 single data bit");
        // R7: clean round trips
        run_vec(8'h00, m_enc(8'h00), "R7 zero");
        run_vec(8'hFF, m_enc(8'hFF), "R7 ones");
        chk("R7 clean no flags", 32'({rd_err, rd_fixed, rd_chk_fault, rd_uncorr}), 32'h0);
        chk("R3 zero syndrome data", 32'(rd_data), 32'hFF);

        // R4/R5: every single flip of a codeword
        base = m_enc(8'h6C);
        for (int p = 1; p <= 12; p++) begin
            run_vec(8'h6C, base ^ 12'(1 << (p - 1)), "R4 R5 single flip");
            chk("R4 R5 repaired data", 32'(rd_data), 32'h6C);
            chk("R4 R5 syndrome equals position", 32'(rd_syndrome), 32'(p));
        end

        // R6: syndromes 13, 14, 15
        run_vec(8'h3C, base ^ 12'h801, "R6 syn13");
        chk("R6 uncorr 13", 32'({rd_fixed, rd_uncorr}), 32'h1);
        run_vec(8'h3C, base ^ 12'h802, "R6 syn14");
        chk("R6 uncorr 14", 32'({rd_err, rd_uncorr}), 32'h3);
        run_vec(8'h3C, base ^ 12'h804, "R6 syn15");
        chk("R6 data unchanged", 32'(rd_data), 32'(m_dec(base ^ 12'h804) >> 8));

        // R5: double fault aliasing to position 6
        run_vec(8'h11, base ^ 12'h014, "R5 alias to pos6");

        // random mixture
        void'($urandom(32'h5EC0DE));
        for (int n = 0; n < 400; n++) begin
            logic [7:0]  d;
            logic [11:0] c;
            int          nf;
            d = 8'($urandom);
            c = m_enc(d);
            nf = $urandom_range(0, 2);
            for (int j = 0; j < nf; j++) c[$urandom_range(0, 11)] ^= 1'b1;
            run_vec(8'($urandom), c, "R3 R4 R5 R6 random");
        end

        // R8: reset mid-run clears outputs
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R8 reset clears", 32'(outs()), 32'h0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule